// File: doc/BRIEF.md
# Configuration Probe Retry Sequencer

This block sits between an enumeration agent and the configuration port of a PCI Express core. It accepts one configuration request at a time. Every attempt runs as a three-step sequence on the downstream port: the target bus and device/function value is written into the core's routing register, that register is read back so the write is known to have landed, and the configuration access itself is then issued.

Devices that are still initialising may answer the identifier read with nothing useful. When a read targets dword 0 of device/function 0 and the value is all zeros or all ones, the block treats the probe as failed. It waits one millisecond and runs the full sequence again. After a bounded number of retries it gives up and reports the device as absent. A bus error on any configuration read is turned into all-ones data, so it does not surface as a fault. Writes are forwarded once and never retried.

Top module: `cprs_probe_retry`

## Requirements
- R1: `req_ready` is high only while the block is idle, and a request is taken only on a clock edge where `req_valid` and `req_ready` are both high. Only one request is in progress at a time.
- R2: Each attempt issues three downstream operations in order, each held until `dn_done`. The operations are: routing write (`dn_op`=0, `dn_wdata`={16'h0, bus, devfn}), routing readback (`dn_op`=1), and configuration access (`dn_op`=2 for read, 3 for write) at `dn_addr`={offset[11:2], 2'b00}.
- R3: A read is a probe only when offset[11:2] is zero and devfn is zero. The byte bits offset[1:0] do not matter. No other read is ever retried.
- R4: A probe whose data is 32'h0 or 32'hFFFFFFFF is a failed probe and is retried while retries remain. A bus error counts as all-ones data for this test.
- R5: Before each retry, `dn_valid` stays low for exactly CLK_KHZ clock cycles, which is one millisecond.
- R6: At most RETRY_LIMIT retries are made. If the last attempt also fails, the response carries status NOT_FOUND (code 1) and data 32'hFFFFFFFF.
- R7: A read that is not a failed probe returns status OK (code 0). Its data is the read value, or 32'hFFFFFFFF when `dn_err` was high.
- R8: A write makes exactly one attempt with `dn_wdata` equal to the request data. It responds with status OK (code 0), or BUS_ERR (code 2) when `dn_err` was high.
- R9: Each request produces exactly one response, signalled by `rsp_valid` high for a single cycle.
- R10: After reset, `req_ready` is high and `rsp_valid` and `dn_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_offset | input | 12 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_status | output | 2 | 0 OK, 1 NOT_FOUND, 2 BUS_ERR |
| dn_valid | output | 1 | Downstream operation pending |
| dn_op | output | 2 | 0 routing write, 1 routing readback, 2 config read, 3 config write |
| dn_addr | output | 12 | Dword-aligned configuration address |
| dn_wdata | output | 32 | Downstream write data |
| dn_done | input | 1 | Downstream operation complete |
| dn_rdata | input | 32 | Downstream read data |
| dn_err | input | 1 | Downstream bus error |

## Verification
The assertions check these properties on every cycle:
- A pending downstream operation stays stable until it completes.
- The block never offers ready while it is driving a downstream operation.
- The response is a single-cycle pulse.
- The retry count never passes its cap.
- A not-found response always carries all-ones data.
- A retry sequence only starts for a probe.

Only the bench scenarios can show the rest: the exact retry counts, the quiet interval between attempts, the conversion of bus errors into data, and the decision to retry or not for each pattern of returned data.

// File: rtl/cprs_pkg.sv
package cprs_pkg;

    typedef enum logic [1:0] {
        OP_BDF_WR = 2'd0,
        OP_BDF_RD = 2'd1,
        OP_CFG_RD = 2'd2,
        OP_CFG_WR = 2'd3
    } dn_op_e;

    typedef enum logic [1:0] {
        STS_OK        = 2'd0,
        STS_NOT_FOUND = 2'd1,
        STS_BUS_ERR   = 2'd2
    } rsp_sts_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BDF_WR,
        S_BDF_RD,
        S_ACCESS,
        S_PAUSE,
        S_RESP
    } seq_state_e;

    typedef struct packed {
        logic        write;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [11:0] offset;
        logic [31:0] wdata;
    } cfg_req_t;

    localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

    // Identifier dword of function 0, read direction only.
    function automatic logic is_id_probe(logic write, logic [7:0] devfn, logic [11:0] offset);
        return !write && (devfn == 8'h00) && (offset[11:2] == 10'h000);
    endfunction

    // Zero and all-ones can never be a real identifier.
    function automatic logic id_unusable(logic [31:0] v);
        return (v == 32'h0) || (v == ALL_ONES);
    endfunction

endpackage

// File: rtl/cprs_pause_timer.sv
module cprs_pause_timer #(
    parameter int CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);
    localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [W-1:0] cnt;
    logic         run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (start) begin
            cnt <= W'(CYCLES - 1);
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign expired = run && (cnt == '0);

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= W'(CYCLES - 1))); // R5

endmodule

// File: rtl/cprs_retry_budget.sv
module cprs_retry_budget #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic consume,
    output logic exhausted,
    output logic used_any
);
    localparam int CW = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)              cnt <= '0;
        else if (consume && !exhausted) cnt <= cnt + 1'b1;
    end

    assign exhausted = (cnt == CW'(LIMIT));
    assign used_any  = (cnt != '0);

    AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT)); // R6

endmodule

// File: rtl/cprs_read_filter.sv
module cprs_read_filter
    import cprs_pkg::*;
(
    input  logic        probe,
    input  logic [31:0] rdata,
    input  logic        err,
    output logic [31:0] data_fixed,
    output logic        probe_failed
);
    always_comb begin
        data_fixed   = err ? ALL_ONES : rdata;
        probe_failed = probe && id_unusable(data_fixed);
    end
endmodule

// File: rtl/cprs_probe_retry.sv
module cprs_probe_retry
    import cprs_pkg::*;
#(
    parameter int CLK_KHZ     = 100000,
    parameter int RETRY_LIMIT = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [7:0]  req_bus,
    input  logic [7:0]  req_devfn,
    input  logic [11:0] req_offset,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic [1:0]  rsp_status,
    output logic        dn_valid,
    output logic [1:0]  dn_op,
    output logic [11:0] dn_addr,
    output logic [31:0] dn_wdata,
    input  logic        dn_done,
    input  logic [31:0] dn_rdata,
    input  logic        dn_err
);
    seq_state_e  state, state_nx;
    cfg_req_t    req_q;
    logic [31:0] rsp_data_q;
    rsp_sts_e    rsp_sts_q;

    logic        accept, probe, probe_failed, exhausted, used_any;
    logic        expired, pause_start, access_done;
    logic [31:0] data_fixed;

    assign accept      = (state == S_IDLE) && req_valid;
    assign probe       = is_id_probe(req_q.write, req_q.devfn, req_q.offset);
    assign access_done = (state == S_ACCESS) && dn_done;
    assign pause_start = access_done && !req_q.write && probe_failed && !exhausted;

    cprs_read_filter u_filter (
        .probe        (probe),
        .rdata        (dn_rdata),
        .err          (dn_err),
        .data_fixed   (data_fixed),
        .probe_failed (probe_failed)
    );

    cprs_pause_timer #(.CYCLES(CLK_KHZ)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (pause_start),
        .expired (expired)
    );

    cprs_retry_budget #(.LIMIT(RETRY_LIMIT)) u_budget (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .consume   (pause_start),
        .exhausted (exhausted),
        .used_any  (used_any)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_BDF_WR;
            S_BDF_WR: if (dn_done)   state_nx = S_BDF_RD;
            S_BDF_RD: if (dn_done)   state_nx = S_ACCESS;
            S_ACCESS: if (dn_done)   state_nx = pause_start ? S_PAUSE : S_RESP;
            S_PAUSE:  if (expired)   state_nx = S_BDF_WR;
            S_RESP:                  state_nx = S_IDLE;
            default:                 state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            req_q      <= '0;
            rsp_data_q <= '0;
            rsp_sts_q  <= STS_OK;
        end else begin
            state <= state_nx;
            if (accept) begin
                req_q.write  <= req_write;
                req_q.bus    <= req_bus;
                req_q.devfn  <= req_devfn;
                req_q.offset <= req_offset;
                req_q.wdata  <= req_wdata;
            end
            if (access_done && !pause_start) begin
                if (req_q.write) begin
                    rsp_data_q <= '0;
                    rsp_sts_q  <= dn_err ? STS_BUS_ERR : STS_OK;
                end else if (probe_failed) begin
                    rsp_data_q <= ALL_ONES;
                    rsp_sts_q  <= STS_NOT_FOUND;
                end else begin
                    rsp_data_q <= data_fixed;
                    rsp_sts_q  <= STS_OK;
                end
            end
        end
    end

    always_comb begin
        dn_valid = 1'b0;
        dn_op    = OP_BDF_WR;
        dn_addr  = '0;
        dn_wdata = '0;
        unique case (state)
            S_BDF_WR: begin
                dn_valid = 1'b1;
                dn_op    = OP_BDF_WR;
                dn_wdata = {16'h0000, req_q.bus, req_q.devfn};
            end
            S_BDF_RD: begin
                dn_valid = 1'b1;
                dn_op    = OP_BDF_RD;
            end
            S_ACCESS: begin
                dn_valid = 1'b1;
                dn_op    = req_q.write ? OP_CFG_WR : OP_CFG_RD;
                dn_addr  = {req_q.offset[11:2], 2'b00};
                dn_wdata = req_q.write ? req_q.wdata : 32'h0;
            end
            default: ;
        endcase
    end

    assign req_ready  = (state == S_IDLE);
    assign rsp_valid  = (state == S_RESP);
    assign rsp_rdata  = rsp_data_q;
    assign rsp_status = rsp_sts_q;

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !dn_valid && !rsp_valid); // R1
    AST_OP_HELD: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_done |=> dn_valid && $stable(dn_op) && $stable(dn_addr) && $stable(dn_wdata)); // R2
    AST_RETRY_ONLY_PROBE: assert property (@(posedge clk) disable iff (rst)
        dn_valid && (dn_op == OP_BDF_WR) && used_any |-> probe); // R3
    AST_NOTFOUND_ONES: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && (rsp_status == STS_NOT_FOUND) |-> rsp_rdata == ALL_ONES); // R6
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R9

endmodule

// File: tb/test_cprs_probe_retry.sv
module test_cprs_probe_retry;
    localparam int KHZ   = 8;
    localparam int LIMIT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_bus = '0, req_devfn = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, dn_valid;
    logic [31:0] rsp_rdata, dn_wdata;
    logic [1:0]  rsp_status, dn_op;
    logic [11:0] dn_addr;
    logic        dn_done = 1'b0, dn_err = 1'b0;
    logic [31:0] dn_rdata = '0;

    int vectors = 0, miscompares = 0, rsp_pulses = 0;
    logic [32:0] script[$];
    logic [1:0]  exp_ops[$];
    int          gaps[$];
    bit          in_gap = 0;
    int          gap_len = 0;

    always #5 clk = ~clk;

    cprs_probe_retry #(.CLK_KHZ(KHZ), .RETRY_LIMIT(LIMIT)) i_cprs_probe_retry (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
        .req_offset(req_offset), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_status(rsp_status), .dn_valid(dn_valid),
        .dn_op(dn_op), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_done(dn_done),
        .dn_rdata(dn_rdata), .dn_err(dn_err));

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Downstream responder: fixed latency, checks each operation against the model.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && dn_valid && !dn_done) begin
                logic [1:0]  eop;
                logic [32:0] s;
                eop = (exp_ops.size() > 0) ? exp_ops.pop_front() : 2'bxx;
                chk(dn_op === eop, "R2 op order", 32'(dn_op), 32'(eop));
                if (dn_op == 2'd0)
                    chk(dn_wdata == {16'h0, req_bus, req_devfn}, "R2 routing data", dn_wdata, {16'h0, req_bus, req_devfn});
                if (dn_op >= 2'd2)
                    chk(dn_addr == {req_offset[11:2], 2'b00}, "R2 dword addr", 32'(dn_addr), 32'({req_offset[11:2], 2'b00}));
                if (dn_op == 2'd3)
                    chk(dn_wdata == req_wdata, "R8 write data", dn_wdata, req_wdata);
                repeat (2) @(negedge clk);
                dn_err   = 1'b0;
                dn_rdata = {16'h0, req_bus, req_devfn};
                if (dn_op >= 2'd2) begin
                    s        = (script.size() > 0) ? script.pop_front() : 33'h0;
                    dn_err   = s[32];
                    dn_rdata = s[31:0];
                end
                dn_done = 1'b1;
                @(negedge clk);
                dn_done = 1'b0;
                dn_err  = 1'b0;
            end
        end
    end

    // Per-clock monitor: ready versus activity, response pulses, quiet gaps.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                chk(!(req_ready && dn_valid), "R1 ready while busy", 32'(req_ready), 32'h0);
                if (rsp_valid) begin
                    rsp_pulses++;
                    in_gap = 0;
                end else if (in_gap) begin
                    if (dn_valid) begin
                        gaps.push_back(gap_len);
                        in_gap = 0;
                    end else begin
                        gap_len++;
                    end
                end
                if (dn_valid && dn_done && dn_op == 2'd2) begin
                    in_gap  = 1;
                    gap_len = 0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        summary();
    end

    // Reference model + driver for one request; s_* give the downstream data per access.
    task automatic run(string req, bit wr, logic [7:0] bus, logic [7:0] devfn,
                       logic [11:0] off, logic [31:0] wd, logic [32:0] s_list[$]);
        bit          probe;
        int          retries = 0, pulses0, waited = 0;
        logic [31:0] e_data = '0;
        logic [1:0]  e_sts = 2'd0;
        probe = !wr && devfn == 8'h00 && off[11:2] == 10'h0;
        script  = s_list;
        exp_ops = {};
        gaps    = {};
        foreach (s_list[i]) begin
            logic [31:0] v;
            exp_ops.push_back(2'd0);
            exp_ops.push_back(2'd1);
            if (wr) begin
                exp_ops.push_back(2'd3);
                e_data = '0;
                e_sts  = s_list[i][32] ? 2'd2 : 2'd0;
                break;
            end
            exp_ops.push_back(2'd2);
            v = s_list[i][32] ? 32'hFFFF_FFFF : s_list[i][31:0];
            if (probe && (v == 0 || v == 32'hFFFF_FFFF)) begin
                if (retries < LIMIT) begin
                    retries++;
                    continue;
                end
                e_data = 32'hFFFF_FFFF;
                e_sts  = 2'd1;
                break;
            end
            e_data = v;
            e_sts  = 2'd0;
            break;
        end
        pulses0 = rsp_pulses;
        @(negedge clk);
        chk(req_ready == 1'b1, {req, " ready when idle (R1)"}, 32'(req_ready), 32'h1);
        req_write = wr; req_bus = bus; req_devfn = devfn; req_offset = off; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        chk(rsp_rdata == e_data, {req, " data"}, rsp_rdata, e_data);
        chk(rsp_status == e_sts, {req, " status"}, 32'(rsp_status), 32'(e_sts));
        chk(exp_ops.size() == 0, {req, " all ops issued (R2)"}, 32'(exp_ops.size()), 32'h0);
        chk(gaps.size() == retries, {req, " retry count (R4 R6)"}, 32'(gaps.size()), 32'(retries));
        foreach (gaps[i])
            chk(gaps[i] == KHZ, {req, " quiet interval (R5)"}, 32'(gaps[i]), 32'(KHZ));
        @(negedge clk);
        chk(rsp_pulses - pulses0 == 1 && !rsp_valid, {req, " single pulse (R9)"},
            32'(rsp_pulses - pulses0), 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'h1);
        chk(!rsp_valid && !dn_valid, "R10 outputs quiet", 32'({rsp_valid, dn_valid}), 32'h0);

        run("R7 plain read", 0, 8'h01, 8'h08, 12'h010, 0, '{33'h0_1234_5678});
        run("R3 probe first try", 0, 8'h02, 8'h00, 12'h000, 0, '{33'h0_10EE_1234});
        run("R4 probe zero then ones", 0, 8'h02, 8'h00, 12'h000, 0,
            '{33'h0_0000_0000, 33'h0_FFFF_FFFF, 33'h0_ABCD_1234});
        run("R6 probe never ready", 0, 8'h03, 8'h00, 12'h000, 0,
            '{33'h0, 33'h0, 33'h0, 33'h0});
        run("R6 probe bus errors", 0, 8'h03, 8'h00, 12'h000, 0,
            '{33'h1_0000_1111, 33'h1_0, 33'h1_0, 33'h1_0});
        run("R7 bus error read", 0, 8'h04, 8'h10, 12'h020, 0, '{33'h1_5555_5555});
        run("R3 byte offset ignored", 0, 8'h05, 8'h00, 12'h003, 0,
            '{33'h0_0000_0000, 33'h0_8086_0001});
        run("R3 devfn nonzero no retry", 0, 8'h05, 8'h01, 12'h000, 0, '{33'h0_0000_0000});
        run("R3 higher offset no retry", 0, 8'h05, 8'h00, 12'h004, 0, '{33'h0_FFFF_FFFF});
        run("R8 write ok", 1, 8'h06, 8'h00, 12'h000, 32'hDEAD_BEEF, '{33'h0_0000_0000});
        run("R8 write bus error", 1, 8'h06, 8'h20, 12'h044, 32'h0000_00A5, '{33'h1_0000_0000});
        summary();
    end

endmodule